// File: doc/BRIEF.md
# Quadratic Ratio-to-Codeword Mapper

This block turns a measured delay-ratio interval index into the tap-select codeword of a digitally controlled ring oscillator. It evaluates a second-order polynomial in the index, using three signed fixed-point coefficients that are trimmed per chip at production test. Because the polynomial maps the ratio straight to a codeword, no separate absolute-delay value is produced on the way. With the coefficients a larger ratio gives a longer oscillator loop for the same target period.

The coefficients arrive once after reset from one-time-programmable storage over a load strobe. A system frequency-recovery loop can nudge the result with up and down pulses. Each pulse moves a signed tuning offset by a given step. That offset is kept across later index updates and is added to every rounded polynomial value. The block evaluates the polynomial in Horner form on one multiply-accumulate datapath. It uses three register stages and then an output register, so each new index or tuning pulse yields a codeword after a fixed latency.

Top module: `ratio_code_mapper`

## Requirements
- R1: The codeword equals a·R² + b·R + c rounded half-up to an integer, plus the tuning offset. R is the index read as an unsigned integer, and a, b, c are two's-complement values with FRAC_W (default 8) fraction bits.
- R2: `code_valid` is high for exactly one cycle, at the third rising edge after the edge that samples a trigger (a fresh index, or a single tune pulse). `code` changes only together with `code_valid`.
- R3: A `tune_up` pulse adds `tune_step` to the offset, and a `tune_dn` pulse subtracts it. Either pulse alone starts a recomputation with the most recent index, or with index 0 if none has arrived yet. Both pulses in the same cycle leave the offset unchanged and start nothing.
- R4: The offset saturates at the limits of an OFS_W-bit signed value (default −128..127) and does not wrap. It keeps its value across recomputations.
- R5: The first `coef_load` after reset captures a, b and c. Later loads are ignored until the next reset.
- R6: With non-negative coefficients and a fixed offset, a larger index never gives a smaller codeword.
- R7: The codeword saturates to 0..2^CODE_W−1 (0..1023 by default) and does not wrap.
- R8: A trigger that arrives while a computation is running is not lost. A second computation starts at the edge where the first result is registered, and it uses the latest index and offset.
- R9: Reset, which is synchronous and active low, clears the codeword, the valid strobe, the offset, the last index and the coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_load | input | 1 | One-cycle strobe carrying coefficients from OTP |
| coef_a | input | COEF_W | Quadratic coefficient, signed fixed point |
| coef_b | input | COEF_W | Linear coefficient, signed fixed point |
| coef_c | input | COEF_W | Constant coefficient, signed fixed point |
| idx_valid | input | 1 | Strobe qualifying `idx` |
| idx | input | IDX_W | Ratio interval index from the detector |
| tune_up | input | 1 | One-cycle request to raise the codeword |
| tune_dn | input | 1 | One-cycle request to lower the codeword |
| tune_step | input | STEP_W | Unsigned step applied by a tune pulse |
| code_valid | output | 1 | One-cycle strobe for a fresh codeword |
| code | output | CODE_W | Oscillator tap-select codeword |

## Verification
The assertions assume that `coef_load`, `idx_valid` and the tune pulses are single-cycle strobes sampled on the rising edge. They also assume that the coefficients are small enough that the Horner accumulator cannot overflow for any index. The bench drives every strobe for exactly one cycle from the falling edge. It uses coefficients whose largest intermediate stays far below the accumulator width. Triggers are spaced apart except in the one test that deliberately queues a second trigger behind a running computation.

// File: rtl/mapper_pkg.sv
// Shared types for the ratio-to-codeword mapper.
package mapper_pkg;
    // Sequencer states of the Horner multiply-accumulate.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MUL_B = 2'd1,
        ST_MUL_C = 2'd2,
        ST_FIN   = 2'd3
    } mac_state_t;
endpackage

// File: rtl/coef_store.sv
// Holds the three polynomial coefficients.
// Captures them on the first load strobe after reset and then locks.
// Assumes coef_load is a single-cycle strobe.
module coef_store #(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [COEF_W-1:0] a_in,
    input  logic signed [COEF_W-1:0] b_in,
    input  logic signed [COEF_W-1:0] c_in,
    output logic signed [COEF_W-1:0] a_q,
    output logic signed [COEF_W-1:0] b_q,
    output logic signed [COEF_W-1:0] c_q
);
    logic locked_q;

    // Capture the coefficients once, then lock until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            c_q      <= '0;
            locked_q <= 1'b0;
        end else if (load && !locked_q) begin
            a_q      <= a_in;
            b_q      <= b_in;
            c_q      <= c_in;
            locked_q <= 1'b1;
        end
    end

    AST_COEF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> $stable({a_q, b_q, c_q})); // R5
endmodule

// File: rtl/tune_offset.sv
// Signed tuning offset driven by up and down pulses.
// The offset saturates at the OFS_W signed limits, and only reset clears it.
// Assumes tune_step is unsigned.
module tune_offset #(
    parameter int OFS_W  = 8,
    parameter int STEP_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up,
    input  logic                    dn,
    input  logic [STEP_W-1:0]       step,
    output logic signed [OFS_W-1:0] ofs_q
);
    localparam int WW = ((OFS_W > STEP_W) ? OFS_W : STEP_W) + 2;
    localparam logic signed [WW-1:0] OFS_MAX_W = WW'((64'sd1 <<< (OFS_W - 1)) - 64'sd1);
    localparam logic signed [WW-1:0] OFS_MIN_W = ~OFS_MAX_W;

    logic signed [WW-1:0] wide_ofs;
    logic signed [WW-1:0] wide_step;
    logic signed [WW-1:0] wide_nxt;
    logic signed [WW-1:0] wide_sat;

    // Widen the operands and apply the step in the requested direction.
    always_comb begin
        wide_ofs  = WW'(ofs_q);
        wide_step = $signed(WW'(step));
        wide_nxt  = up ? (wide_ofs + wide_step) : (wide_ofs - wide_step);
        if (wide_nxt > OFS_MAX_W)      wide_sat = OFS_MAX_W;
        else if (wide_nxt < OFS_MIN_W) wide_sat = OFS_MIN_W;
        else                           wide_sat = wide_nxt;
    end

    // Update the offset on a lone pulse; simultaneous pulses cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)        ofs_q <= '0;
        else if (up ^ dn)  ofs_q <= OFS_W'(wide_sat);
    end

    AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up == dn) |=> $stable(ofs_q)); // R4
endmodule

// File: rtl/horner_mac.sv
// Evaluates ((a*R) + b)*R + c on one multiply-accumulate in three steps.
// A trigger in IDLE or FIN starts a run. A trigger during a run is queued.
// Assumes the accumulator width covers the largest intermediate value.
module horner_mac
    import mapper_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     trig,
    input  logic                     idx_valid,
    input  logic [IDX_W-1:0]         idx,
    input  logic signed [COEF_W-1:0] a,
    input  logic signed [COEF_W-1:0] b,
    input  logic signed [COEF_W-1:0] c,
    output logic signed [ACC_W-1:0]  acc_q,
    output logic                     fin
);
    mac_state_t              state_q;
    logic [IDX_W-1:0]        r_last_q;
    logic [IDX_W-1:0]        r_cur_q;
    logic                    pend_q;
    logic                    start;
    logic [IDX_W-1:0]        r_sel;
    logic signed [ACC_W-1:0] r_ext;
    logic signed [ACC_W-1:0] prod;

    assign fin   = (state_q == ST_FIN);
    assign start = (trig || pend_q) && (state_q == ST_IDLE || state_q == ST_FIN);
    assign r_sel = idx_valid ? idx : r_last_q;
    assign r_ext = $signed(ACC_W'(r_cur_q));
    assign prod  = acc_q * r_ext;

    // Remember the most recent index for tune-triggered runs.
    always_ff @(posedge clk) begin
        if (!rst_n)         r_last_q <= '0;
        else if (idx_valid) r_last_q <= idx;
    end

    // Queue a trigger that arrives while the datapath is busy.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (start) pend_q <= 1'b0;
        else if (trig)  pend_q <= 1'b1;
    end

    // Sequence the Horner steps and accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            r_cur_q <= '0;
        end else begin
            case (state_q)
                ST_MUL_B: begin
                    acc_q   <= prod + ACC_W'(b);
                    state_q <= ST_MUL_C;
                end
                ST_MUL_C: begin
                    acc_q   <= prod + ACC_W'(c);
                    state_q <= ST_FIN;
                end
                default: begin
                    if (start) begin
                        acc_q   <= ACC_W'(a);
                        r_cur_q <= r_sel;
                        state_q <= ST_MUL_B;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    AST_SEQ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL_C) |-> ($past(state_q) == ST_MUL_B)); // R2
    AST_FIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |-> ($past(state_q) == ST_MUL_C)); // R2
endmodule

// File: rtl/code_clamp.sv
// Rounds the fixed-point accumulator half-up to an integer.
// Then adds the tuning offset and saturates to the codeword range.
// Purely combinational. Assumes acc + one half does not overflow ACC_W.
module code_clamp #(
    parameter int ACC_W  = 32,
    parameter int FRAC_W = 8,
    parameter int OFS_W  = 8,
    parameter int CODE_W = 10
) (
    input  logic signed [ACC_W-1:0] acc,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [CODE_W-1:0]       code
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'd1 << (FRAC_W - 1));
    localparam logic signed [SUM_W-1:0] CODE_MAX_S = SUM_W'((64'd1 << CODE_W) - 64'd1);

    logic signed [ACC_W-1:0] rounded;
    logic signed [SUM_W-1:0] sum;

    // Round half-up, add the offset, then clamp to the legal range.
    always_comb begin
        rounded = (acc + HALF) >>> FRAC_W;
        sum     = SUM_W'(rounded) + SUM_W'(ofs);
        if (sum < 0)               code = '0;
        else if (sum > CODE_MAX_S) code = CODE_W'(CODE_MAX_S);
        else                       code = CODE_W'(sum);
    end
endmodule

// File: rtl/ratio_code_mapper.sv
// Top of the quadratic ratio-to-codeword mapper.
// A fresh index or a lone tune pulse starts a Horner evaluation.
// The rounded, offset and clamped result is registered 3 cycles after the trigger edge.
// Assumes every input strobe is a single cycle.
module ratio_code_mapper #(
    parameter int IDX_W  = 7,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 8,
    parameter int CODE_W = 10,
    parameter int OFS_W  = 8,
    parameter int STEP_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     coef_load,
    input  logic signed [COEF_W-1:0] coef_a,
    input  logic signed [COEF_W-1:0] coef_b,
    input  logic signed [COEF_W-1:0] coef_c,
    input  logic                     idx_valid,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     tune_up,
    input  logic                     tune_dn,
    input  logic [STEP_W-1:0]        tune_step,
    output logic                     code_valid,
    output logic [CODE_W-1:0]        code
);
    localparam int ACC_W = COEF_W + 2 * IDX_W + 2;

    logic signed [COEF_W-1:0] a_q, b_q, c_q;
    logic signed [OFS_W-1:0]  ofs_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic                     fin;
    logic                     trig;
    logic [CODE_W-1:0]        code_nxt;

    assign trig = idx_valid || (tune_up ^ tune_dn);

    coef_store #(.COEF_W(COEF_W)) i_coef_store (
        .clk(clk), .rst_n(rst_n), .load(coef_load),
        .a_in(coef_a), .b_in(coef_b), .c_in(coef_c),
        .a_q(a_q), .b_q(b_q), .c_q(c_q)
    );

    tune_offset #(.OFS_W(OFS_W), .STEP_W(STEP_W)) i_tune_offset (
        .clk(clk), .rst_n(rst_n), .up(tune_up), .dn(tune_dn),
        .step(tune_step), .ofs_q(ofs_q)
    );

    horner_mac #(.IDX_W(IDX_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) i_horner_mac (
        .clk(clk), .rst_n(rst_n), .trig(trig), .idx_valid(idx_valid), .idx(idx),
        .a(a_q), .b(b_q), .c(c_q), .acc_q(acc_q), .fin(fin)
    );

    code_clamp #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .OFS_W(OFS_W), .CODE_W(CODE_W)) i_code_clamp (
        .acc(acc_q), .ofs(ofs_q), .code(code_nxt)
    );

    // Register the finished codeword and pulse the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code       <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= fin;
            if (fin) code <= code_nxt;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid); // R2
    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> $stable(code)); // R2
endmodule

// File: tb/test_ratio_code_mapper.sv
module test_ratio_code_mapper;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              coef_load = 1'b0;
    logic signed [15:0] coef_a = '0, coef_b = '0, coef_c = '0;
    logic              idx_valid = 1'b0;
    logic [6:0]        idx = '0;
    logic              tune_up = 1'b0, tune_dn = 1'b0;
    logic [6:0]        tune_step = '0;
    logic              code_valid;
    logic [9:0]        code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Coefficients a=0.5, b=2.25, c=10 (Q8): code = round(0.5R^2 + 2.25R + 10)
    localparam int NV = 8;
    localparam int TV_IDX[NV] = '{0, 1, 2, 3, 10, 40, 45, 127};
    localparam int TV_EXP[NV] = '{10, 13, 17, 21, 83, 900, 1023, 1023};

    always #2 clk = ~clk;

    ratio_code_mapper i_ratio_code_mapper (
        .clk(clk), .rst_n(rst_n), .coef_load(coef_load),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .idx_valid(idx_valid), .idx(idx),
        .tune_up(tune_up), .tune_dn(tune_dn), .tune_step(tune_step),
        .code_valid(code_valid), .code(code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_coefs(input int a, input int b, input int c);
        coef_load = 1'b1; coef_a = 16'(a); coef_b = 16'(b); coef_c = 16'(c);
        @(negedge clk);
        coef_load = 1'b0;
    endtask

    task automatic send_idx(input int v);
        idx_valid = 1'b1; idx = 7'(v);
        @(negedge clk);
        idx_valid = 1'b0;
    endtask

    task automatic send_tune(input bit up, input bit dn, input int st);
        tune_up = up; tune_dn = dn; tune_step = 7'(st);
        @(negedge clk);
        tune_up = 1'b0; tune_dn = 1'b0;
    endtask

    // Called one falling edge after the trigger was driven.
    task automatic expect_result(input string req, input int exp);
        @(negedge clk);
        @(negedge clk);
        chk({req, " R2 early valid"}, int'(code_valid), 0);
        @(negedge clk);
        chk({req, " R2 valid"}, int'(code_valid), 1);
        chk(req, int'(code), exp);
        @(negedge clk);
        chk({req, " R2 pulse width"}, int'(code_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int prev;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", int'(code_valid), 0);
        chk("R9 reset code", int'(code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: first load captures, second load must be ignored
        load_coefs(128, 576, 2560);
        load_coefs(0, 0, 0);

        prev = 0;
        for (int i = 0; i < NV; i++) begin
            send_idx(TV_IDX[i]);
            expect_result("R1 R5 R7 table", TV_EXP[i]);
            n_chk++;
            if (int'(code) < prev) begin
                n_fail++;
                $display("FAIL R6 monotonic: actual %0d expected >= %0d", code, prev);
            end
            prev = int'(code);
        end

        // R3: tune up shifts the last index's codeword
        send_idx(3);
        expect_result("R1 idx3", 21);
        send_tune(1, 0, 5);
        expect_result("R3 tune up", 26);
        // R4: offset persists across a fresh index
        send_idx(1);
        expect_result("R4 persist", 18);
        // R7: low clamp
        send_tune(0, 1, 100);
        expect_result("R7 low clamp", 0);
        // R4: saturation at -128, then +127 gives -1
        send_tune(0, 1, 100);
        expect_result("R4 sat low", 0);
        send_tune(1, 0, 127);
        expect_result("R4 after sat", 12);
        // R3: both pulses together cancel and trigger nothing
        send_tune(1, 1, 50);
        for (int k = 0; k < 6; k++) begin
            chk("R3 no trigger", int'(code_valid), 0);
            @(negedge clk);
        end
        send_idx(2);
        expect_result("R3 offset unchanged", 16);

        // R8: second index queued behind a running computation
        idx_valid = 1'b1; idx = 7'd10;
        @(negedge clk);
        idx = 7'd40;
        @(negedge clk);
        idx_valid = 1'b0;
        @(negedge clk);
        chk("R8 first early", int'(code_valid), 0);
        @(negedge clk);
        chk("R8 first valid", int'(code_valid), 1);
        chk("R8 first code", int'(code), 82);
        @(negedge clk);
        chk("R8 gap", int'(code_valid), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R8 second valid", int'(code_valid), 1);
        chk("R8 second code", int'(code), 899);
        @(negedge clk);

        // R9: reset clears offset and coefficients
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 mid reset valid", int'(code_valid), 0);
        chk("R9 mid reset code", int'(code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        load_coefs(0, 256, -512);
        send_idx(1);
        expect_result("R7 R9 negative clamp", 0);
        send_idx(100);
        expect_result("R1 R9 offset cleared", 98);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule